// File: doc/BRIEF.md
# Register-Mapped MDIO Frame Controller

This block is a management-interface master for serial PHY configuration. Software controls it through two 32-bit registers. The control register holds a clock divisor and a preamble switch, and it reports a completion flag. The frame register holds a packed word that carries the start flag, the operation, the device and register fields, the turnaround pattern and the write data. A valid frame write launches one serial transaction on MDC/MDIO. Software then polls the completion flag and reads the 16-bit result from the low half of the frame register.

An extended addressing mode is selected by a strap input. In that mode the controller first sends a block-select write frame. That frame carries the block number taken from the device field of the written word. The real frame follows, with the device field cleared. When the preamble is on, each frame on the wire is preceded by a run of ones.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After synchronous reset both registers read zero, MDC is low, the MDIO output enable is low and no transaction runs.
- R2: Control register layout: bits 6:0 hold the divisor and bit 7 enables the preamble. Both read back as written. Bit 8 is the read-only completion flag. All other bits read zero.
- R3: Writing the frame register while idle with bit 30 set and exactly one of bit 29 (read) or bit 28 (write) set starts a transaction. The 32-bit word goes out MSB first, one bit per MDC period. MDIO changes while MDC is low, so each bit is stable at the rising MDC edge.
- R4: One MDC period lasts 2×(divisor+1) clock cycles, low half first. A transaction of B bits on the wire sets the completion flag exactly B×2×(divisor+1) cycles after the launching write edge. The flag stays clear before that.
- R5: With the preamble enabled, 32 ones are driven, with output enable high, before every frame.
- R6: In a read, the output enable is low for the last 18 bits (frame bits 17 down to 0). MDIO input is sampled at the clock edge where MDC rises during bits 15..0. On completion, the 16 samples (first sample as MSB) replace frame register bits 15:0, and bits 31:16 keep the written value.
- R7: With ext_addr_mode high, a select write frame is sent first. Its word is 0x5000_0000 | (0x1F<<18) | (1<<17) | (blk<<4), where blk is bits 26:22 of the written word. The main frame follows with bits 26:22 forced to zero.
- R8: A frame register write while a transaction runs has no effect: the register contents and the transaction on the wire are unchanged.
- R9: Writing all zeros to the control register aborts any transaction at once. After the abort the block is idle, MDC is low, the output enable is low and the preamble is disabled. The completion flag keeps its value.
- R10: A frame write while idle that lacks the start bit, or that has both or neither operation bits, is stored but starts nothing.
- R11: Every frame write accepted while idle clears the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control register, 1 selects frame register |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register read value |
| frame_rdata | output | 32 | Frame register read value |
| ext_addr_mode | input | 1 | Strap selecting the two-frame extended addressing mode |
| mdio_i | input | 1 | MDIO line input |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The completion flag is due exactly B×2×(divisor+1) cycles after the write edge. B is 32 per frame, plus 32 per frame when the preamble is on, with two frames in extended mode. The bench samples the flag on the falling clock edge one cycle before that point, where it must be clear, and again on the edge after, where it must be set. Each wire bit is compared one time unit after the rising MDC that closes its first half, and read-data bits are driven just after the falling MDC edge. The effects of a register write (readback, abort, flag clear) are checked on the falling edge right after the write edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS  = 32;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    localparam int RD_BITS     = 16;

    // frame word field positions (wire order is MSB first)
    localparam int START_BIT   = 30;
    localparam int RD_BIT      = 29;
    localparam int WR_BIT      = 28;
    localparam int DEV_LSB     = 22;
    localparam int DEV_W       = 5;
    localparam int REG_LSB     = 18;
    localparam int TA_BIT      = 17;
    localparam int SEL_BLK_LSB = 4;
    localparam logic [4:0] SEL_REG_ADDR = 5'h1F;

    // bit indices (counted from the first wire bit) of read turnaround and data
    localparam int RD_RELEASE_IDX = FRAME_BITS - 1 - TA_BIT;
    localparam int RD_DATA_IDX    = FRAME_BITS - RD_BITS;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PRE   = 2'd1,
        SEQ_FRAME = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic        valid;
        logic [31:0] word;
    } launch_t;

    function automatic logic frame_is_valid(input logic [31:0] w);
        return w[START_BIT] && (w[RD_BIT] != w[WR_BIT]);
    endfunction

    function automatic logic [31:0] select_word(input logic [DEV_W-1:0] blk);
        logic [31:0] w;
        w = '0;
        w[START_BIT] = 1'b1;
        w[WR_BIT]    = 1'b1;
        w[TA_BIT]    = 1'b1;
        w[REG_LSB +: 5] = SEL_REG_ADDR;
        w[SEL_BLK_LSB +: DEV_W] = blk;
        return w;
    endfunction

    function automatic logic [31:0] strip_device(input logic [31:0] w);
        logic [31:0] r;
        r = w;
        r[DEV_LSB +: DEV_W] = '0;
        return r;
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_end
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign half_end = run && (cnt_q == div);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               sel,
    input  logic [31:0]        wdata,
    input  logic               busy,
    input  logic               done_pulse,
    input  logic               rd_valid,
    input  logic [RD_BITS-1:0] rd_result,
    output logic [31:0]        ctrl_rdata,
    output logic [31:0]        frame_rdata,
    output logic               pre_en,
    output logic [DIV_W-1:0]   div,
    output logic               abort,
    output launch_t            launch
);

    localparam int PRE_EN_BIT = 7;
    localparam int DONE_BIT   = 8;

    logic             pre_en_q;
    logic [DIV_W-1:0] div_q;
    logic             done_q;
    logic [31:0]      frame_q;
    logic             ctrl_wr;
    logic             frame_wr;

    assign ctrl_wr  = wr_en && !sel;
    assign frame_wr = wr_en && sel && !busy;
    assign abort    = ctrl_wr && (wdata == 32'd0);

    assign launch.valid = frame_wr && frame_is_valid(wdata);
    assign launch.word  = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_en_q <= 1'b0;
            div_q    <= '0;
            done_q   <= 1'b0;
            frame_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                pre_en_q <= wdata[PRE_EN_BIT];
                div_q    <= wdata[DIV_W-1:0];
            end
            if (frame_wr) begin
                frame_q <= wdata;
                done_q  <= 1'b0;
            end else if (done_pulse) begin
                done_q <= 1'b1;
                if (rd_valid) begin
                    frame_q[RD_BITS-1:0] <= rd_result;
                end
            end
        end
    end

    always_comb begin
        ctrl_rdata             = '0;
        ctrl_rdata[DIV_W-1:0]  = div_q;
        ctrl_rdata[PRE_EN_BIT] = pre_en_q;
        ctrl_rdata[DONE_BIT]   = done_q;
    end

    assign frame_rdata = frame_q;
    assign pre_en      = pre_en_q;
    assign div         = div_q;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  launch_t            launch,
    input  logic               ext_mode,
    input  logic               pre_en,
    input  logic               abort,
    input  logic               half_end,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done_pulse,
    output logic               rd_valid,
    output logic [RD_BITS-1:0] rd_result
);

    localparam logic [IDX_W-1:0] LAST_PRE   = IDX_W'(PRE_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] REL_IDX    = IDX_W'(RD_RELEASE_IDX);
    localparam logic [IDX_W-1:0] DATA_IDX   = IDX_W'(RD_DATA_IDX);

    seq_state_e         st_q;
    logic               phase_q;
    logic [IDX_W-1:0]   idx_q;
    logic [31:0]        shreg_q;
    logic [31:0]        main_q;
    logic               sel_pend_q;
    logic               rd_q;
    logic [RD_BITS-1:0] rdata_q;

    logic in_main;
    logic last_bit;
    logic bit_end;
    logic rise;
    logic releasing;

    assign in_main   = (st_q == SEQ_FRAME) && !sel_pend_q;
    assign last_bit  = (st_q == SEQ_PRE) ? (idx_q == LAST_PRE) : (idx_q == LAST_FRAME);
    assign bit_end   = half_end && phase_q;
    assign rise      = half_end && !phase_q;
    assign releasing = in_main && rd_q && (idx_q >= REL_IDX);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st_q       <= SEQ_IDLE;
            phase_q    <= 1'b0;
            idx_q      <= '0;
            shreg_q    <= '0;
            main_q     <= '0;
            sel_pend_q <= 1'b0;
            rd_q       <= 1'b0;
            rdata_q    <= '0;
        end else if (st_q == SEQ_IDLE) begin
            if (launch.valid) begin
                rd_q    <= launch.word[RD_BIT];
                phase_q <= 1'b0;
                idx_q   <= '0;
                st_q    <= pre_en ? SEQ_PRE : SEQ_FRAME;
                if (ext_mode) begin
                    shreg_q    <= select_word(launch.word[DEV_LSB +: DEV_W]);
                    main_q     <= strip_device(launch.word);
                    sel_pend_q <= 1'b1;
                end else begin
                    shreg_q    <= launch.word;
                    main_q     <= launch.word;
                    sel_pend_q <= 1'b0;
                end
            end
        end else begin
            if (rise) begin
                phase_q <= 1'b1;
                if (in_main && rd_q && (idx_q >= DATA_IDX)) begin
                    rdata_q <= {rdata_q[RD_BITS-2:0], mdio_i};
                end
            end
            if (bit_end) begin
                phase_q <= 1'b0;
                if (last_bit) begin
                    idx_q <= '0;
                    if (st_q == SEQ_PRE) begin
                        st_q <= SEQ_FRAME;
                    end else if (sel_pend_q) begin
                        sel_pend_q <= 1'b0;
                        shreg_q    <= main_q;
                        st_q       <= pre_en ? SEQ_PRE : SEQ_FRAME;
                    end else begin
                        st_q <= SEQ_IDLE;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                    if (st_q == SEQ_FRAME) begin
                        shreg_q <= {shreg_q[30:0], 1'b0};
                    end
                end
            end
        end
    end

    assign busy       = (st_q != SEQ_IDLE);
    assign mdc        = phase_q;
    assign mdio_oe    = busy && !releasing;
    assign mdio_o     = mdio_oe && ((st_q == SEQ_PRE) || shreg_q[31]);
    assign done_pulse = bit_end && last_bit && in_main;
    assign rd_valid   = done_pulse && rd_q;
    assign rd_result  = rdata_q;

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W    = 7,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] frame_rdata,
    input  logic        ext_addr_mode,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);

    logic               busy;
    logic               done_pulse;
    logic               rd_valid;
    logic [RD_BITS-1:0] rd_result;
    logic               pre_en;
    logic [DIV_W-1:0]   div;
    logic               abort;
    logic               half_end;
    launch_t            launch;

    mdio_regs #(.DIV_W(DIV_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rd_valid   (rd_valid),
        .rd_result  (rd_result),
        .ctrl_rdata (ctrl_rdata),
        .frame_rdata(frame_rdata),
        .pre_en     (pre_en),
        .div        (div),
        .abort      (abort),
        .launch     (launch)
    );

    mdio_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .div     (div),
        .half_end(half_end)
    );

    mdio_seq #(.PRE_BITS(PRE_BITS)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .ext_mode  (ext_addr_mode),
        .pre_en    (pre_en),
        .abort     (abort),
        .half_end  (half_end),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done_pulse(done_pulse),
        .rd_valid  (rd_valid),
        .rd_result (rd_result)
    );

endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] ctrl_rdata,
    input logic [31:0] frame_rdata,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        busy,
    input logic        done_pulse
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_sel && !busy && reg_wdata[30] && (reg_wdata[29] != reg_wdata[28]))
        |=> busy);

    assert_mdc_busy_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> $past(busy));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_sel && busy && !done_pulse) |=> $stable(frame_rdata));

    assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !reg_sel && (reg_wdata == 32'd0)) |=> (!busy && !mdc && !mdio_oe));

    assert_done_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_sel && !busy) |=> !ctrl_rdata[8]);

endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .ctrl_rdata (ctrl_rdata),
    .frame_rdata(frame_rdata),
    .mdc        (mdc),
    .mdio_oe    (mdio_oe),
    .busy       (busy),
    .done_pulse (done_pulse)
);

// File: tb/mdio_frame_ctrl_tb_top.sv
module mdio_frame_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       oe;
        logic       val;
        logic       drv;
        logic [1:0] tag; // 0:R3 1:R5 2:R6 3:R7
    } bit_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [31:0] frame_rdata;
    logic        ext_addr_mode = 1'b0;
    logic        mdio_i = 1'b0;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_frame_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_wr_en    (reg_wr_en),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .ctrl_rdata   (ctrl_rdata),
        .frame_rdata  (frame_rdata),
        .ext_addr_mode(ext_addr_mode),
        .mdio_i       (mdio_i),
        .mdc          (mdc),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe)
    );

    function automatic string tag_name(input logic [1:0] t);
        case (t)
            2'd1:    return "R5";
            2'd2:    return "R6";
            2'd3:    return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input bit rd, input logic [4:0] dev,
                                       input logic [3:0] ra, input logic [15:0] data);
        logic [31:0] w;
        w = 32'h4002_0000;
        w[29] = rd;
        w[28] = !rd;
        w[26:22] = dev;
        w[21:18] = ra;
        w[15:0] = data;
        return w;
    endfunction

    task automatic push_pre();
        for (int i = 0; i < 32; i++) exp_q.push_back('{1'b1, 1'b1, 1'b0, 2'd1});
    endtask

    task automatic push_word(input logic [31:0] w, input bit rd, input logic [15:0] resp,
                             input logic [1:0] tag);
        for (int i = 31; i >= 0; i--) begin
            if (rd && i <= 17)
                exp_q.push_back('{1'b0, 1'b0, (i <= 15) ? resp[i] : 1'b0, 2'd2});
            else
                exp_q.push_back('{1'b1, w[i], 1'b0, tag});
        end
    endtask

    // one write per clock cycle; called and returns on a falling edge
    task automatic reg_write(input bit sel, input logic [31:0] data);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // scoreboard driver: predicts the wire bits and the completion time
    task automatic run_txn(input logic [31:0] w, input bit ext, input bit pre, input int dv,
                           input logic [15:0] resp, input bit poke);
        bit rd;
        int nbits;
        int t;
        logic [31:0] main_w;
        logic [31:0] sel_w;
        rd = w[29];
        nbits = 0;
        main_w = w;
        if (ext) begin
            sel_w = 32'h5002_0000 | (32'h1F << 18) | (32'(w[26:22]) << 4);
            main_w[26:22] = 5'd0;
            if (pre) begin push_pre(); nbits += 32; end
            push_word(sel_w, 1'b0, 16'h0, 2'd3);
            nbits += 32;
        end
        if (pre) begin push_pre(); nbits += 32; end
        push_word(main_w, rd, resp, 2'd0);
        nbits += 32;
        t = nbits * 2 * (dv + 1);
        ext_addr_mode = ext;
        reg_write(1'b1, w);
        if (poke) begin
            repeat (19) @(negedge clk);
            reg_write(1'b1, 32'h6000_FFFF);
            check(frame_rdata == w, "R8", frame_rdata, w);
            repeat (t - 21) @(negedge clk);
        end else begin
            repeat (t - 1) @(negedge clk);
        end
        check(ctrl_rdata[8] == 1'b0, "R4", 32'(ctrl_rdata[8]), 32'd0);
        @(negedge clk);
        check(ctrl_rdata[8] == 1'b1, "R4", 32'(ctrl_rdata[8]), 32'd1);
        check(exp_q.size() == 0, "R3", exp_q.size(), 32'd0);
        if (rd) check(frame_rdata == {w[31:16], resp}, "R6", frame_rdata, {w[31:16], resp});
        else    check(frame_rdata == w, "R3", frame_rdata, w);
    endtask

    // scoreboard monitor: compares each bit at the rising MDC
    always @(posedge mdc) begin
        bit_item_t it;
        #1;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3", 32'd1, 32'd0);
        end else begin
            it = exp_q.pop_front();
            check(mdio_oe == it.oe, tag_name(it.tag), 32'(mdio_oe), 32'(it.oe));
            if (it.oe) check(mdio_o == it.val, tag_name(it.tag), 32'(mdio_o), 32'(it.val));
        end
    end

    // PHY model: presents the next read data bit while MDC is low
    always @(negedge mdc) begin
        #1;
        mdio_i = (exp_q.size() > 0) ? exp_q[0].drv : 1'b0;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(ctrl_rdata == 32'd0, "R1", ctrl_rdata, 32'd0);
        check(frame_rdata == 32'd0, "R1", frame_rdata, 32'd0);
        check({mdc, mdio_oe} == 2'b00, "R1", 32'({mdc, mdio_oe}), 32'd0);

        // R2 control layout, divisor 2, preamble on
        reg_write(1'b0, 32'hFFFF_FE82);
        check(ctrl_rdata == 32'h0000_0082, "R2", ctrl_rdata, 32'h82);

        // R3 R4 R5 write frame with preamble
        run_txn(mk(1'b0, 5'd3, 4'h5, 16'hA5C3), 1'b0, 1'b1, 2, 16'h0, 1'b0);

        // R9 zero control write keeps completion flag
        reg_write(1'b0, 32'd0);
        check(ctrl_rdata == 32'h0000_0100, "R9", ctrl_rdata, 32'h100);

        // R6 read, divisor 0, no preamble
        reg_write(1'b0, 32'h0000_0000);
        run_txn(mk(1'b1, 5'd9, 4'hA, 16'h0000), 1'b0, 1'b0, 0, 16'h3C96, 1'b0);

        // R7 extended mode read, divisor 1, preamble on
        reg_write(1'b0, 32'h0000_0081);
        check(ctrl_rdata[7:0] == 8'h81, "R2", 32'(ctrl_rdata[7:0]), 32'h81);
        run_txn(mk(1'b1, 5'd5, 4'h2, 16'h0000), 1'b1, 1'b1, 1, 16'hC35A, 1'b0);
        // R7 extended mode write
        run_txn(mk(1'b0, 5'd17, 4'h7, 16'h1E2D), 1'b1, 1'b1, 1, 16'h0, 1'b0);

        // R8 frame write during a transaction ignored
        reg_write(1'b0, 32'h0000_0001);
        run_txn(mk(1'b0, 5'd1, 4'h3, 16'hBEEF), 1'b0, 1'b0, 1, 16'h0, 1'b1);

        // R10 R11 non-launching frame writes
        reg_write(1'b1, 32'h0000_1234);
        check(ctrl_rdata[8] == 1'b0, "R11", 32'(ctrl_rdata[8]), 32'd0);
        check(frame_rdata == 32'h0000_1234, "R10", frame_rdata, 32'h1234);
        reg_write(1'b1, 32'h7000_0000);
        repeat (12) @(negedge clk);
        check({mdc, mdio_oe} == 2'b00, "R10", 32'({mdc, mdio_oe}), 32'd0);
        check(frame_rdata == 32'h7000_0000, "R10", frame_rdata, 32'h7000_0000);

        // R9 abort in the middle of a transaction
        reg_write(1'b0, 32'h0000_0082);
        push_pre();
        push_word(mk(1'b0, 5'd2, 4'h1, 16'h5555), 1'b0, 16'h0, 2'd0);
        reg_write(1'b1, mk(1'b0, 5'd2, 4'h1, 16'h5555));
        repeat (40) @(negedge clk);
        reg_write(1'b0, 32'd0);
        exp_q.delete();
        check({mdc, mdio_oe} == 2'b00, "R9", 32'({mdc, mdio_oe}), 32'd0);
        check(ctrl_rdata == 32'd0, "R9", ctrl_rdata, 32'd0);
        repeat (20) @(negedge clk);
        check({mdc, mdio_oe} == 2'b00, "R9", 32'({mdc, mdio_oe}), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule